// File: doc/BRIEF.md
# Boot-Read Triggered Crowbar Strobe Timer

This block listens to the serial command line of an eMMC bus, sampled on the same clock that is fed to the target device. Once armed, it decodes each 48-bit host command token. When it sees a read of the boot sector, it starts a cycle-exact countdown. When the countdown ends, it raises a single strobe that drives an external crowbar switch. The strobe is held for a programmed number of cycles and then released, and a one-cycle completion pulse follows.

Delay and width are counted in clock cycles of the target clock, so the strobe keeps a fixed phase relation to the target. The delay counter reaches past 41000 cycles and the width counter past 55 cycles. The block fires at most once per arming. Commands that arrive while it is disarmed, counting down or pulsing have no effect.

Top module: `glitch_strobe_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `crowbar_drive`, `busy` and `done` low from the next cycle. It aborts any pending countdown or active strobe, and no `done` pulse follows.
- R2: A command token is 48 bits, sent MSB first on `cmd_line`, which idles high. It starts on a falling line: start bit 0, then a transmission bit, 6 index bits, 32 argument bits, 7 CRC bits and an end bit. Only tokens with transmission bit 1, end bit 1 and a correct CRC are considered. The CRC is x^7+x^3+1 with zero initial value, taken over the first 40 bits.
- R3: A token triggers only when its index is 17 or 18 and its argument equals the target sector (parameter, default 0). Any other index or argument is ignored.
- R4: Let the end bit of a triggering token be sampled at clock edge E. With delay N, `crowbar_drive` is first high after edge E+1+N. N = 0 is allowed.
- R5: `crowbar_drive` stays high for exactly M cycles and then goes low. M = 0 produces no strobe at all.
- R6: `done` is high for exactly one cycle, in the first cycle after the strobe falls. When M = 0, that is the cycle after edge E+1+N.
- R7: `busy` is high for exactly N+M cycles, starting after edge E+1, and `done` never overlaps `busy`.
- R8: The block listens only while `arm_en` is high. Arming takes one cycle in idle. Lowering `arm_en` while listening disarms the block. After a trigger is accepted, further matching tokens are ignored until `arm_en` is seen high again in idle.
- R9: `delay_cycles` and `width_cycles` are sampled at the edge that accepts the trigger. Later changes have no effect on that strobe.
- R10: The delay range covers 17-bit values, including delays near 40810 cycles with widths near 50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock; all sampling and counting |
| rst | input | 1 | Synchronous reset, active high |
| cmd_line | input | 1 | eMMC command line, sampled each cycle |
| arm_en | input | 1 | Arm request / listen enable |
| delay_cycles | input | 17 | Cycles from trigger acceptance to strobe rise |
| width_cycles | input | 16 | Strobe length in cycles |
| crowbar_drive | output | 1 | Crowbar switch drive strobe |
| busy | output | 1 | Countdown or strobe in progress |
| done | output | 1 | One-cycle pulse after the strobe ends |

## Verification
A bit-count slip in the deserialiser shows up as a missing trigger, or as a strobe whose rise moves by whole cycles. That error is visible at the strobe edge no later than N+1 cycles after the end bit. A counter that is off by one in either phase moves the rise or fall of `crowbar_drive` by one cycle and changes the length of `busy` by one cycle. A stuck arming state shows up at the ports as a second strobe from a token sent while disarmed, or as no strobe at all. The sweep over small delays and widths therefore checks every edge position against arithmetic, including the zero cases where the strobe or the countdown vanishes.

// File: rtl/gsg_pkg.sv
package gsg_pkg;

   localparam int TOKEN_BITS = 48;
   localparam int CRC_BITS   = 7;
   localparam int CRC_SPAN   = 40;
   localparam int IDX_BITS   = 6;
   localparam int ARG_BITS   = 32;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LISTEN = 2'd1,
      ST_DELAY  = 2'd2,
      ST_PULSE  = 2'd3
   } tmr_state_e;

   // one serial step of the x^7 + x^3 + 1 code
   function automatic logic [CRC_BITS-1:0] crc7_step(input logic [CRC_BITS-1:0] c,
                                                    input logic b);
      logic fb;
      fb = b ^ c[6];
      return {c[5:3], c[2] ^ fb, c[1:0], fb};
   endfunction

endpackage

// File: rtl/gsg_token_deser.sv
module gsg_token_deser
   import gsg_pkg::*;
#(
   parameter int FRAME_BITS = TOKEN_BITS
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  line_in,
   output logic                  tok_valid,
   output logic [FRAME_BITS-1:0] tok_bits,
   output logic [CRC_BITS-1:0]   crc_calc
);

   localparam int CNT_W = $clog2(FRAME_BITS);

   logic             shifting;
   logic [CNT_W-1:0] bit_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         shifting  <= 1'b0;
         bit_cnt   <= '0;
         tok_valid <= 1'b0;
         tok_bits  <= '0;
         crc_calc  <= '0;
      end else begin
         tok_valid <= 1'b0;
         if (!shifting) begin
            // a low level on an idle line opens a token
            if (!line_in) begin
               shifting <= 1'b1;
               bit_cnt  <= CNT_W'(1);
               tok_bits <= {tok_bits[FRAME_BITS-2:0], 1'b0};
               crc_calc <= crc7_step('0, 1'b0);
            end
         end else begin
            tok_bits <= {tok_bits[FRAME_BITS-2:0], line_in};
            if (bit_cnt < CNT_W'(CRC_SPAN)) begin
               crc_calc <= crc7_step(crc_calc, line_in);
            end
            if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
               shifting  <= 1'b0;
               bit_cnt   <= '0;
               tok_valid <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/gsg_read_match.sv
module gsg_read_match
   import gsg_pkg::*;
#(
   parameter logic [ARG_BITS-1:0] TARGET_SECTOR = '0,
   parameter int                  IDX_SINGLE    = 17,
   parameter int                  IDX_MULTI     = 18,
   parameter bit                  CHECK_CRC     = 1'b1
) (
   input  logic                  tok_valid,
   input  logic [TOKEN_BITS-1:0] tok_bits,
   input  logic [CRC_BITS-1:0]   crc_calc,
   output logic                  hit
);

   logic                start_b;
   logic                dir_b;
   logic [IDX_BITS-1:0] idx_f;
   logic [ARG_BITS-1:0] arg_f;
   logic [CRC_BITS-1:0] crc_f;
   logic                stop_b;
   logic                frame_ok;
   logic                crc_ok;
   logic                is_read;

   assign start_b = tok_bits[47];
   assign dir_b   = tok_bits[46];
   assign idx_f   = tok_bits[45:40];
   assign arg_f   = tok_bits[39:8];
   assign crc_f   = tok_bits[7:1];
   assign stop_b  = tok_bits[0];

   assign frame_ok = !start_b && dir_b && stop_b;

   generate
      if (CHECK_CRC) begin : g_crc_on
         assign crc_ok = (crc_calc == crc_f);
      end else begin : g_crc_off
         assign crc_ok = 1'b1;
      end
   endgenerate

   assign is_read = (idx_f == IDX_BITS'(IDX_SINGLE)) || (idx_f == IDX_BITS'(IDX_MULTI));

   assign hit = tok_valid && frame_ok && crc_ok && is_read && (arg_f == TARGET_SECTOR);

endmodule

// File: rtl/gsg_pulse_timer.sv
module gsg_pulse_timer
   import gsg_pkg::*;
#(
   parameter int DELAY_W = 17,
   parameter int WIDTH_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               arm_en,
   input  logic               hit,
   input  logic [DELAY_W-1:0] delay_in,
   input  logic [WIDTH_W-1:0] width_in,
   output logic               crowbar,
   output logic               busy,
   output logic               done
);

   tmr_state_e         state;
   logic [DELAY_W-1:0] dcnt;
   logic [WIDTH_W-1:0] wcnt;
   logic [WIDTH_W-1:0] wlat;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         dcnt  <= '0;
         wcnt  <= '0;
         wlat  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (arm_en) state <= ST_LISTEN;
            end
            ST_LISTEN: begin
               if (!arm_en) begin
                  state <= ST_IDLE;
               end else if (hit) begin
                  wlat <= width_in;
                  if (delay_in == '0) begin
                     if (width_in == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                     end else begin
                        state <= ST_PULSE;
                        wcnt  <= width_in;
                     end
                  end else begin
                     state <= ST_DELAY;
                     dcnt  <= delay_in;
                  end
               end
            end
            ST_DELAY: begin
               if (dcnt == DELAY_W'(1)) begin
                  if (wlat == '0) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     state <= ST_PULSE;
                     wcnt  <= wlat;
                  end
               end else begin
                  dcnt <= dcnt - DELAY_W'(1);
               end
            end
            ST_PULSE: begin
               if (wcnt == WIDTH_W'(1)) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  wcnt <= wcnt - WIDTH_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign crowbar = (state == ST_PULSE);
   assign busy    = (state == ST_DELAY) || (state == ST_PULSE);

endmodule

// File: rtl/glitch_strobe_gen.sv
module glitch_strobe_gen
   import gsg_pkg::*;
#(
   parameter int                  DELAY_W       = 17,
   parameter int                  WIDTH_W       = 16,
   parameter logic [ARG_BITS-1:0] TARGET_SECTOR = '0,
   parameter int                  IDX_SINGLE    = 17,
   parameter int                  IDX_MULTI     = 18,
   parameter bit                  CHECK_CRC     = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmd_line,
   input  logic               arm_en,
   input  logic [DELAY_W-1:0] delay_cycles,
   input  logic [WIDTH_W-1:0] width_cycles,
   output logic               crowbar_drive,
   output logic               busy,
   output logic               done
);

   localparam int MIN_DELAY_W = $clog2(41000 + 1);
   localparam int MIN_WIDTH_W = $clog2(55 + 1);
   localparam int IDX_LIMIT   = 1 << IDX_BITS;

   generate
      if (DELAY_W < MIN_DELAY_W) begin : g_bad_delay_w
         $error("glitch_strobe_gen: DELAY_W too narrow for the required delay range");
      end
      if (WIDTH_W < MIN_WIDTH_W) begin : g_bad_width_w
         $error("glitch_strobe_gen: WIDTH_W too narrow for the required width range");
      end
      if (IDX_SINGLE >= IDX_LIMIT || IDX_MULTI >= IDX_LIMIT) begin : g_bad_idx
         $error("glitch_strobe_gen: read index does not fit the index field");
      end
   endgenerate

   logic                  tok_valid;
   logic [TOKEN_BITS-1:0] tok_bits;
   logic [CRC_BITS-1:0]   crc_calc;
   logic                  read_hit;

   gsg_token_deser #(
      .FRAME_BITS(TOKEN_BITS)
   ) i_deser (
      .clk      (clk),
      .rst      (rst),
      .line_in  (cmd_line),
      .tok_valid(tok_valid),
      .tok_bits (tok_bits),
      .crc_calc (crc_calc)
   );

   gsg_read_match #(
      .TARGET_SECTOR(TARGET_SECTOR),
      .IDX_SINGLE   (IDX_SINGLE),
      .IDX_MULTI    (IDX_MULTI),
      .CHECK_CRC    (CHECK_CRC)
   ) i_match (
      .tok_valid(tok_valid),
      .tok_bits (tok_bits),
      .crc_calc (crc_calc),
      .hit      (read_hit)
   );

   gsg_pulse_timer #(
      .DELAY_W(DELAY_W),
      .WIDTH_W(WIDTH_W)
   ) i_timer (
      .clk     (clk),
      .rst     (rst),
      .arm_en  (arm_en),
      .hit     (read_hit),
      .delay_in(delay_cycles),
      .width_in(width_cycles),
      .crowbar (crowbar_drive),
      .busy    (busy),
      .done    (done)
   );

endmodule

// File: rtl/gsg_checker.sv
module gsg_checker (
   input logic clk,
   input logic rst,
   input logic arm_en,
   input logic hit,
   input logic crowbar,
   input logic busy,
   input logic done
);

   // R1
   rst_clears_chk: assert property (@(posedge clk)
      rst |=> (!crowbar && !busy && !done));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R6
   done_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(crowbar) && !$past(rst)) |-> done);

   // R5
   pulse_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
      crowbar |-> busy);

   // R7
   done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   // R8
   accept_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> ($past(arm_en) && $past(hit)));

endmodule

bind glitch_strobe_gen gsg_checker i_gsg_checker (
   .clk    (clk),
   .rst    (rst),
   .arm_en (arm_en),
   .hit    (read_hit),
   .crowbar(crowbar_drive),
   .busy   (busy),
   .done   (done)
);

// File: tb/test_glitch_strobe_gen.sv
module test_glitch_strobe_gen;

   logic        clk = 1'b0;
   logic        rst;
   logic        cmd_line;
   logic        arm_en;
   logic [16:0] delay_cycles;
   logic [15:0] width_cycles;
   logic        crowbar_drive;
   logic        busy;
   logic        done;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int t_last   = 0;
   bit finished = 1'b0;

   int rise_cyc;
   int hi_cnt;
   int busy_cnt;
   int done_cnt;
   int done_cyc;

   glitch_strobe_gen i_glitch_strobe_gen (
      .clk          (clk),
      .rst          (rst),
      .cmd_line     (cmd_line),
      .arm_en       (arm_en),
      .delay_cycles (delay_cycles),
      .width_cycles (width_cycles),
      .crowbar_drive(crowbar_drive),
      .busy         (busy),
      .done         (done)
   );

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (crowbar_drive) begin
         if (rise_cyc < 0) rise_cyc = cyc;
         hi_cnt++;
      end
      if (busy) busy_cnt++;
      if (done) begin
         done_cnt++;
         done_cyc = cyc;
      end
   end

   function automatic logic [6:0] crc7(input logic [39:0] d);
      logic [6:0] c;
      c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic fb;
         fb = d[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      rise_cyc = -1;
      hi_cnt   = 0;
      busy_cnt = 0;
      done_cnt = 0;
      done_cyc = -1;
   endtask

   task automatic send_token(input logic [5:0] idx, input logic [31:0] arg,
                             input bit bad_crc, input bit dir, input bit stop);
      logic [39:0] head;
      logic [6:0]  c;
      logic [47:0] f;
      head = {1'b0, dir, idx, arg};
      c    = crc7(head);
      if (bad_crc) c = c ^ 7'h01;
      f = {head, c, stop};
      for (int i = 47; i >= 0; i--) begin
         @(negedge clk);
         cmd_line = f[i];
      end
      @(negedge clk);
      cmd_line = 1'b1;
      t_last   = cyc;
   endtask

   task automatic run_fire(input int n, input int m, input logic [5:0] idx);
      delay_cycles = 17'(n);
      width_cycles = 16'(m);
      arm_en = 1'b1;
      repeat (2) @(negedge clk);
      clear_mon();
      send_token(idx, 32'd0, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      arm_en = 1'b0;
      repeat (n + m + 6) @(negedge clk);
      if (m > 0) check("R4 strobe rise offset", rise_cyc - t_last, n + 1);
      else       check("R5 zero width gives no strobe", rise_cyc, -1);
      check("R5 strobe width", hi_cnt, m);
      check("R6 done offset", done_cyc - t_last, n + m + 1);
      check("R6 done length", done_cnt, 1);
      check("R7 busy length", busy_cnt, n + m);
   endtask

   task automatic silent_token(input string req, input logic [5:0] idx, input logic [31:0] arg,
                               input bit bad_crc, input bit dir, input bit stop, input bit armed);
      delay_cycles = 17'd2;
      width_cycles = 16'd2;
      arm_en = armed;
      repeat (2) @(negedge clk);
      clear_mon();
      send_token(idx, arg, bad_crc, dir, stop);
      repeat (12) @(negedge clk);
      arm_en = 1'b0;
      repeat (2) @(negedge clk);
      check(req, hi_cnt + busy_cnt + done_cnt, 0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      cmd_line = 1'b1;
      arm_en = 1'b0;
      delay_cycles = '0;
      width_cycles = '0;
      clear_mon();
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset crowbar", int'(crowbar_drive), 0);
      check("R1 reset busy", int'(busy), 0);
      check("R1 reset done", int'(done), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      // R4 R5 R6 R7 sweep over small delays and widths, both read indices (R3)
      for (int n = 0; n <= 5; n++) begin
         for (int m = 0; m <= 4; m++) begin
            run_fire(n, m, ((n + m) % 2 == 0) ? 6'd17 : 6'd18);
         end
      end

      // R3 other indices and other sectors
      silent_token("R3 write index ignored", 6'd24, 32'd0, 1'b0, 1'b1, 1'b1, 1'b1);
      silent_token("R3 index 16 ignored", 6'd16, 32'd0, 1'b0, 1'b1, 1'b1, 1'b1);
      silent_token("R3 sector 1 ignored", 6'd17, 32'd1, 1'b0, 1'b1, 1'b1, 1'b1);
      silent_token("R3 high sector ignored", 6'd18, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b1);

      // R2 framing and CRC
      silent_token("R2 bad CRC ignored", 6'd17, 32'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      silent_token("R2 transmission bit 0 ignored", 6'd17, 32'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      silent_token("R2 end bit 0 ignored", 6'd17, 32'd0, 1'b0, 1'b1, 1'b0, 1'b1);

      // R8 not armed
      silent_token("R8 disarmed token ignored", 6'd17, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0);

      // R8 arm then withdraw before the token
      arm_en = 1'b1;
      repeat (3) @(negedge clk);
      arm_en = 1'b0;
      repeat (2) @(negedge clk);
      silent_token("R8 withdrawn arm ignored", 6'd18, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0);

      // R8 no second strobe without re-arming
      run_fire(2, 2, 6'd17);
      silent_token("R8 second token after fire ignored", 6'd17, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0);

      // R8 R9 token during countdown, inputs changed after acceptance
      begin
         int t0;
         delay_cycles = 17'd100;
         width_cycles = 16'd3;
         arm_en = 1'b1;
         repeat (2) @(negedge clk);
         clear_mon();
         send_token(6'd17, 32'd0, 1'b0, 1'b1, 1'b1);
         t0 = t_last;
         @(negedge clk);
         arm_en = 1'b0;
         delay_cycles = 17'd7;
         width_cycles = 16'd9;
         send_token(6'd18, 32'd0, 1'b0, 1'b1, 1'b1);
         repeat (80) @(negedge clk);
         check("R9 latched delay", rise_cyc - t0, 101);
         check("R9 latched width", hi_cnt, 3);
         check("R8 one strobe per arm", done_cnt, 1);
         check("R6 done offset after latched values", done_cyc - t0, 104);
      end

      // R10 long delay in the working range
      run_fire(40810, 50, 6'd18);

      // R1 abort during an active strobe
      delay_cycles = 17'd3;
      width_cycles = 16'd20;
      arm_en = 1'b1;
      repeat (2) @(negedge clk);
      clear_mon();
      send_token(6'd17, 32'd0, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      arm_en = 1'b0;
      repeat (8) @(negedge clk);
      check("R1 strobe active before abort", int'(crowbar_drive), 1);
      rst = 1'b1;
      @(negedge clk);
      check("R1 abort drops strobe", int'(crowbar_drive), 0);
      check("R1 abort drops busy", int'(busy), 0);
      @(negedge clk);
      rst = 1'b0;
      clear_mon();
      repeat (30) @(negedge clk);
      check("R1 no activity after abort", hi_cnt + busy_cnt + done_cnt, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule